// File: doc/BRIEF.md
# Speculative Store Dirty-Marking Gate

This block sits between the store path of an out-of-order core and the line-state array of a secondary cache. For every accepted store it decides which line-state update to issue. When deferred-dirty mode is active, it holds back the Dirty Exclusive marking until the store can no longer be squashed. While a store is speculative, its target line may only be raised as far as Clean Exclusive. A fill for a miss, or the upgrade of a Shared hit, happens at once; a Shared hit also raises a request for ownership on the bus. The final dirty marking is issued by a timer a fixed number of cycles after the store becomes the oldest entry of the active list.

Whether the mode is active depends on the privilege level. Kernel and supervisor code follow a configuration bit that is captured while reset is held and is fixed from then on. User code follows a separate status bit. One deferred marking may be in flight at a time, and the store port stalls any other store that would need one. A store that needs no deferral still passes. The block also gates loads to non-coherent regions, which wait until they are oldest in every mode.

Line-state encoding: 00 Invalid, 01 Shared, 10 Clean Exclusive, 11 Dirty Exclusive. Privilege encoding: 00 kernel, 01 supervisor, 10 and 11 user.

Top module: `spec_dirty_ctl`

## Requirements
- R1: The mode is active at privilege 00 or 01 when the captured configuration bit is 1. At privilege 10 or 11 it is active when `stat_defer_user` is 1.
- R2: `cfg_defer_boot` is sampled only on clock edges while `rst_n` is low. Changes after reset have no effect on the mode.
- R3: With the mode active, an accepted store never produces an update with state 11 in its acceptance cycle. A miss (`st_hit`=0) or a hit on state 01 issues an update to state 10 for `st_idx` in that same cycle. A hit on state 10 issues no update.
- R4: With the mode inactive, an accepted store that misses or hits state 00, 01 or 10 issues an update to state 11 for `st_idx` in the same cycle, and `dirty_busy` stays 0.
- R5: A store that hits a line in state 11 is accepted with no update and no deferral, in either mode, even while a deferral is in flight.
- R6: An accepted store that hits state 01 raises `upg_req` in its acceptance cycle.
- R7: A deferred marking issues an update to state 11 for the saved index exactly DIRTY_LAT cycles after the store became oldest. That point is the acceptance cycle if `st_oldest` was 1 then, otherwise the cycle in which `st_retire` is 1. `dirty_busy` is 1 from the cycle after acceptance up to and including the update cycle.
- R8: `st_flush` while a deferral still waits for its store to become oldest cancels it. `dirty_busy` falls after the next edge and no state-11 update follows.
- R9: While `dirty_busy` is 1, a store that would need a deferral sees `st_ready`=0. `st_ready` is also 0 in the cycle a deferred update is issued. After reset, `st_ready` is 1 and `upd_valid` and `dirty_busy` are 0.
- R10: A load with `ld_noncoh`=1 gets `ld_go`=1 only when `ld_oldest`=1, in both modes. A coherent load gets `ld_go` as soon as it is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the configuration bit is captured while low |
| cfg_defer_boot | input | 1 | Configuration bit enabling deferral at kernel/supervisor level |
| stat_defer_user | input | 1 | Status bit enabling deferral at user level |
| priv_lvl | input | 2 | Current privilege level |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when valid |
| st_idx | input | IDX_W | Line index of the store |
| st_hit | input | 1 | Store hit in the secondary cache |
| st_state | input | 2 | Current state of the hit line |
| st_oldest | input | 1 | Store is oldest in the active list at request |
| st_retire | input | 1 | Waiting deferred store has become oldest |
| st_flush | input | 1 | Waiting deferred store has been squashed |
| upd_valid | output | 1 | Line-state update command valid |
| upd_idx | output | IDX_W | Line index to update |
| upd_state | output | 2 | New line state |
| upg_req | output | 1 | Bus ownership upgrade request |
| dirty_busy | output | 1 | A deferred dirty marking is in flight |
| ld_valid | input | 1 | Load request valid |
| ld_noncoh | input | 1 | Load targets a non-coherent region |
| ld_oldest | input | 1 | Load is oldest in the active list |
| ld_go | output | 1 | Load may issue |

## Verification
The bench builds the block with a 6-bit line index and the default 10-cycle dirty latency. The narrow index lets random stores reuse the same lines often and keeps the saved-index comparison meaningful. A latency of 10 keeps each deferral short enough for a few hundred random deferrals to run, and long enough that every intermediate cycle of the count is seen to stay quiet. The configuration bit is captured as 1 and then driven to 0, so the privilege level and the user status bit decide the mode through all random traffic.

// File: rtl/spec_dirty_pkg.sv
package spec_dirty_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_CLE = 2'b10,
      LS_DRX = 2'b11
   } line_state_e;

   typedef enum logic [1:0] {
      PRV_KERN = 2'b00,
      PRV_SUPV = 2'b01,
      PRV_USER = 2'b10,
      PRV_USR2 = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      DT_IDLE  = 2'b00,
      DT_WAIT  = 2'b01,
      DT_COUNT = 2'b10
   } defer_st_e;
endpackage

// File: rtl/spec_dirty_mode.sv
module spec_dirty_mode
   import spec_dirty_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boot_bit,
   input  logic       user_bit,
   input  logic [1:0] priv,
   output logic       active
);
   logic boot_q;

   // captured only while reset is held; frozen afterwards
   always_ff @(posedge clk) begin
      if (!rst_n) boot_q <= boot_bit;
   end

   always_comb begin
      if (priv == PRV_KERN || priv == PRV_SUPV) active = boot_q;
      else                                      active = user_bit;
   end
endmodule

// File: rtl/spec_dirty_decide.sv
module spec_dirty_decide
   import spec_dirty_pkg::*;
(
   input  logic       mode_on,
   input  logic       hit,
   input  logic [1:0] cur_state,
   output logic       need_defer,
   output logic       imm_valid,
   output logic [1:0] imm_state,
   output logic       want_upg
);
   line_state_e eff;

   always_comb begin
      eff        = hit ? line_state_e'(cur_state) : LS_INV;
      need_defer = mode_on && (eff != LS_DRX);
      want_upg   = hit && (line_state_e'(cur_state) == LS_SHR);
      imm_valid  = 1'b0;
      imm_state  = LS_DRX;
      if (eff != LS_DRX) begin
         if (mode_on) begin
            imm_valid = (eff != LS_CLE);
            imm_state = LS_CLE;
         end else begin
            imm_valid = 1'b1;
            imm_state = LS_DRX;
         end
      end
   end
endmodule

// File: rtl/spec_dirty_timer.sv
module spec_dirty_timer
   import spec_dirty_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int DIRTY_LAT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_now,
   input  logic             start_wait,
   input  logic [IDX_W-1:0] start_idx,
   input  logic             retire,
   input  logic             flush,
   output logic             busy,
   output logic             fire,
   output logic [IDX_W-1:0] fire_idx
);
   localparam int CNT_W = (DIRTY_LAT > 2) ? $clog2(DIRTY_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DIRTY_LAT - 1);

   defer_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= DT_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
      end else begin
         unique case (st_q)
            DT_IDLE: begin
               if (start_now) begin
                  st_q  <= DT_COUNT;
                  cnt_q <= CNT_LOAD;
                  idx_q <= start_idx;
               end else if (start_wait) begin
                  st_q  <= DT_WAIT;
                  idx_q <= start_idx;
               end
            end
            DT_WAIT: begin
               if (flush) begin
                  st_q <= DT_IDLE;
               end else if (retire) begin
                  st_q  <= DT_COUNT;
                  cnt_q <= CNT_LOAD;
               end
            end
            DT_COUNT: begin
               if (cnt_q == '0) st_q <= DT_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= DT_IDLE;
         endcase
      end
   end

   assign busy     = (st_q != DT_IDLE);
   assign fire     = (st_q == DT_COUNT) && (cnt_q == '0);
   assign fire_idx = idx_q;
endmodule

// File: rtl/spec_dirty_ctl.sv
module spec_dirty_ctl
   import spec_dirty_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int DIRTY_LAT = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_defer_boot,
   input  logic             stat_defer_user,
   input  logic [1:0]       priv_lvl,
   input  logic             st_valid,
   output logic             st_ready,
   input  logic [IDX_W-1:0] st_idx,
   input  logic             st_hit,
   input  logic [1:0]       st_state,
   input  logic             st_oldest,
   input  logic             st_retire,
   input  logic             st_flush,
   output logic             upd_valid,
   output logic [IDX_W-1:0] upd_idx,
   output logic [1:0]       upd_state,
   output logic             upg_req,
   output logic             dirty_busy,
   input  logic             ld_valid,
   input  logic             ld_noncoh,
   input  logic             ld_oldest,
   output logic             ld_go
);
   generate
      if (DIRTY_LAT < 2) begin : g_bad_lat
         $error("spec_dirty_ctl: DIRTY_LAT must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("spec_dirty_ctl: IDX_W must be at least 1");
      end
   endgenerate

   logic             mode_act;
   logic             need_defer, imm_valid, want_upg;
   logic [1:0]       imm_state;
   logic             tm_busy, tm_fire;
   logic [IDX_W-1:0] tm_idx;
   logic             accept;

   spec_dirty_mode u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_bit (cfg_defer_boot),
      .user_bit (stat_defer_user),
      .priv     (priv_lvl),
      .active   (mode_act)
   );

   spec_dirty_decide u_decide (
      .mode_on    (mode_act),
      .hit        (st_hit),
      .cur_state  (st_state),
      .need_defer (need_defer),
      .imm_valid  (imm_valid),
      .imm_state  (imm_state),
      .want_upg   (want_upg)
   );

   spec_dirty_timer #(
      .IDX_W     (IDX_W),
      .DIRTY_LAT (DIRTY_LAT)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_now  (accept && need_defer && st_oldest),
      .start_wait (accept && need_defer && !st_oldest),
      .start_idx  (st_idx),
      .retire     (st_retire),
      .flush      (st_flush),
      .busy       (tm_busy),
      .fire       (tm_fire),
      .fire_idx   (tm_idx)
   );

   // the single update port belongs to the timer in its firing cycle
   assign st_ready = !tm_fire && !(need_defer && tm_busy);
   assign accept   = st_valid && st_ready;

   always_comb begin
      upd_valid = 1'b0;
      upd_idx   = st_idx;
      upd_state = imm_state;
      if (tm_fire) begin
         upd_valid = 1'b1;
         upd_idx   = tm_idx;
         upd_state = LS_DRX;
      end else if (accept && imm_valid) begin
         upd_valid = 1'b1;
      end
   end

   assign upg_req    = accept && want_upg;
   assign dirty_busy = tm_busy;
   assign ld_go      = ld_valid && (!ld_noncoh || ld_oldest);
endmodule

// File: rtl/spec_dirty_chk.sv
module spec_dirty_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_act,
   input logic       st_valid,
   input logic       st_ready,
   input logic       st_hit,
   input logic [1:0] st_state,
   input logic       upd_valid,
   input logic [1:0] upd_state,
   input logic       upg_req,
   input logic       dirty_busy,
   input logic       ld_valid,
   input logic       ld_noncoh,
   input logic       ld_oldest,
   input logic       ld_go
);
   logic acc, hit_drx;
   assign acc     = st_valid && st_ready;
   assign hit_drx = st_hit && (st_state == 2'b11);

   AST_SPEC_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_act) |-> !(upd_valid && upd_state == 2'b11)); // R3
   AST_OFF_DIRTY_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !mode_act && !hit_drx) |-> (upd_valid && upd_state == 2'b11)); // R4
   AST_DIRTY_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && hit_drx) |-> !upd_valid); // R5
   AST_SHARED_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_act && st_hit && st_state == 2'b01)
         |-> (upg_req && upd_valid && upd_state == 2'b10)); // R6
   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_act && !hit_drx) |=> dirty_busy); // R7
   AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_busy && st_valid && mode_act && !hit_drx) |-> !st_ready); // R9
   AST_NONCOH_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && ld_noncoh && !ld_oldest) |-> !ld_go); // R10
endmodule

bind spec_dirty_ctl spec_dirty_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_act   (mode_act),
   .st_valid   (st_valid),
   .st_ready   (st_ready),
   .st_hit     (st_hit),
   .st_state   (st_state),
   .upd_valid  (upd_valid),
   .upd_state  (upd_state),
   .upg_req    (upg_req),
   .dirty_busy (dirty_busy),
   .ld_valid   (ld_valid),
   .ld_noncoh  (ld_noncoh),
   .ld_oldest  (ld_oldest),
   .ld_go      (ld_go)
);

// File: tb/spec_dirty_ctl_bench.sv
`timescale 1ns/1ps
module spec_dirty_ctl_bench;
   localparam int IDX_W = 6;
   localparam int LAT   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_defer_boot = 1'b1, stat_defer_user = 1'b0;
   logic [1:0] priv_lvl = 2'b00;
   logic st_valid = 1'b0, st_hit = 1'b0, st_oldest = 1'b0;
   logic st_retire = 1'b0, st_flush = 1'b0;
   logic [IDX_W-1:0] st_idx = '0;
   logic [1:0] st_state = 2'b00;
   logic ld_valid = 1'b0, ld_noncoh = 1'b0, ld_oldest = 1'b0;
   logic st_ready, upd_valid, upg_req, dirty_busy, ld_go;
   logic [IDX_W-1:0] upd_idx;
   logic [1:0] upd_state;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   spec_dirty_ctl #(.IDX_W(IDX_W), .DIRTY_LAT(LAT)) u_spec_dirty_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_defer_boot(cfg_defer_boot),
      .stat_defer_user(stat_defer_user), .priv_lvl(priv_lvl),
      .st_valid(st_valid), .st_ready(st_ready), .st_idx(st_idx),
      .st_hit(st_hit), .st_state(st_state), .st_oldest(st_oldest),
      .st_retire(st_retire), .st_flush(st_flush), .upd_valid(upd_valid),
      .upd_idx(upd_idx), .upd_state(upd_state), .upg_req(upg_req),
      .dirty_busy(dirty_busy), .ld_valid(ld_valid), .ld_noncoh(ld_noncoh),
      .ld_oldest(ld_oldest), .ld_go(ld_go)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // expected immediate update {valid, state} from the requirements
   function automatic logic [2:0] exp_imm(input logic mode, input logic hit, input logic [1:0] st);
      logic [1:0] eff;
      eff = hit ? st : 2'b00;
      if (eff == 2'b11) return 3'b000;
      if (mode) return (eff == 2'b10) ? 3'b000 : 3'b110;
      return 3'b111;
   endfunction

   function automatic logic exp_mode(input logic [1:0] pv, input logic us);
      return (pv < 2) ? 1'b1 : us; // configuration captured as 1
   endfunction

   task automatic put_store(input logic hit, input logic [1:0] st, input logic old,
                            input logic [IDX_W-1:0] idx);
      @(negedge clk);
      st_valid = 1'b1; st_hit = hit; st_state = st; st_oldest = old; st_idx = idx;
      #1;
   endtask

   task automatic end_store();
      @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   // called just after the edge that started the count (R7)
   task automatic expect_fire(input logic [IDX_W-1:0] idx);
      for (int i = 1; i < LAT; i++) begin
         @(negedge clk);
         check(!upd_valid && dirty_busy, "R7 quiet during count", upd_valid, 0);
         @(posedge clk);
      end
      @(negedge clk);
      check(upd_valid && upd_state == 2'b11 && upd_idx == idx, "R7 dirty set at latency",
            {upd_valid, upd_state, upd_idx}, {1'b1, 2'b11, idx});
      check(!st_ready, "R9 ready low in fire cycle", st_ready, 0);
      @(posedge clk);
      @(negedge clk);
      check(!dirty_busy, "R7 busy clears", dirty_busy, 0);
   endtask

   task automatic do_retire();
      @(negedge clk); st_retire = 1'b1;
      @(posedge clk); #1 st_retire = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk); st_flush = 1'b1;
      @(posedge clk); #1 st_flush = 1'b0;
      @(negedge clk);
      check(!dirty_busy, "R8 flush cancels", dirty_busy, 0);
      for (int i = 0; i < LAT + 2; i++) begin
         @(negedge clk);
         check(!upd_valid, "R8 no dirty after flush", upd_valid, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [2:0] e;
      logic m;
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(st_ready && !upd_valid && !dirty_busy, "R9 reset state",
            {st_ready, upd_valid, dirty_busy}, 3'b100);
      cfg_defer_boot = 1'b0; // R2: must have no effect now

      // R2/R3: kernel, miss, not oldest -> clean exclusive fill, then deferral
      put_store(1'b0, 2'b00, 1'b0, 6'd17);
      check(upd_valid && upd_state == 2'b10 && upd_idx == 6'd17, "R2 R3 miss fills clean",
            {upd_valid, upd_state}, 3'b110);
      end_store();
      repeat (3) begin
         @(negedge clk);
         check(dirty_busy && !upd_valid, "R3 waits for oldest", dirty_busy, 1);
      end
      do_retire();
      expect_fire(6'd17);

      // R6/R9/R5/R8: shared hit, speculative, then stall and flush
      put_store(1'b1, 2'b01, 1'b0, 6'd5);
      check(upg_req && upd_valid && upd_state == 2'b10, "R6 shared upgrade",
            {upg_req, upd_valid, upd_state}, 4'b1110);
      end_store();
      put_store(1'b0, 2'b00, 1'b1, 6'd9);
      check(!st_ready && !upd_valid, "R9 second deferral stalls", st_ready, 0);
      st_valid = 1'b0;
      put_store(1'b1, 2'b11, 1'b0, 6'd9);
      check(st_ready && !upd_valid, "R5 dirty hit passes quietly", {st_ready, upd_valid}, 2'b10);
      end_store();
      do_flush();

      // R1/R4: user level, status bit clear -> immediate dirty
      priv_lvl = 2'b10; stat_defer_user = 1'b0;
      put_store(1'b1, 2'b10, 1'b0, 6'd33);
      check(upd_valid && upd_state == 2'b11 && upd_idx == 6'd33, "R1 R4 immediate dirty",
            {upd_valid, upd_state}, 3'b111);
      end_store();
      @(negedge clk);
      check(!dirty_busy, "R4 no busy", dirty_busy, 0);
      stat_defer_user = 1'b1;
      put_store(1'b1, 2'b10, 1'b1, 6'd34);
      check(!upd_valid, "R1 user mode on, clean hit no update", upd_valid, 0);
      end_store();
      expect_fire(6'd34);

      // R10: loads
      @(negedge clk);
      ld_valid = 1'b1; ld_noncoh = 1'b1; ld_oldest = 1'b0; #1;
      check(!ld_go, "R10 noncoherent held", ld_go, 0);
      ld_oldest = 1'b1; #1;
      check(ld_go, "R10 noncoherent oldest", ld_go, 1);
      ld_noncoh = 1'b0; ld_oldest = 1'b0; stat_defer_user = 1'b0; #1;
      check(ld_go, "R10 coherent goes", ld_go, 1);
      ld_valid = 1'b0;

      // random phase
      for (int n = 0; n < 300; n++) begin
         logic [1:0] pv, sst;
         logic us, hh, oo;
         logic [IDX_W-1:0] ix;
         pv = 2'($urandom); us = 1'($urandom); hh = 1'($urandom);
         sst = 2'($urandom); oo = 1'($urandom); ix = IDX_W'($urandom);
         @(negedge clk);
         priv_lvl = pv; stat_defer_user = us;
         put_store(hh, sst, oo, ix);
         m = exp_mode(pv, us);
         e = exp_imm(m, hh, sst);
         check(st_ready, "R9 idle accepts", st_ready, 1);
         check(upd_valid == e[2] && (!e[2] || (upd_state == e[1:0] && upd_idx == ix)),
               m ? "R3 random immediate" : "R4 random immediate",
               {upd_valid, upd_state}, e);
         check(upg_req == (hh && sst == 2'b01), "R6 random upgrade", upg_req, hh && sst == 2'b01);
         end_store();
         if (m && !(hh && sst == 2'b11)) begin
            if (oo) expect_fire(ix);
            else begin
               repeat (1 + ($urandom % 3)) @(posedge clk);
               if ($urandom % 2) begin
                  do_retire();
                  expect_fire(ix);
               end else do_flush();
            end
         end else begin
            @(negedge clk);
            check(!dirty_busy, "R5 no deferral", dirty_busy, 0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule